// File: doc/BRIEF.md
# Two-level paged address translator

This block turns an 18-bit word address of a 36-bit-word machine into a physical word address. A page is 512 words. A small translation cache sits in front of page tables kept in main memory. In supervisor (exec) mode the lower half of the address space passes through untranslated. The upper half is looked up in one table. In user mode the lower and upper halves each have their own table. Each table is described by a base register that holds a table origin and a length limit.

A request latches the address, the mode and the access kind. On a cache hit the result returns two clock edges later. On a miss the block reads one table word through a 36-bit memory port. That word holds the entries of an even/odd page pair, and both go into the cache. The block stamps the current age value into the accessed half and writes the word back. It then checks the access code. A separate load command fetches the age, a trap-address register, the three base registers and an accumulator pointer from a block of words in memory. A fault stays flagged, and holds off all further work, until it is acknowledged.

Top module: `page_xlat`

## Requirements
- R1: With `pg_en_i` low at request time, the result is `paddr_o` equal to `vaddr_i` with no fault and no memory access.
- R2: An exec request (`user_i` low) to a page 0..255 (vaddr bit 17 clear) returns `paddr_o` equal to `vaddr_i` with no memory access.
- R3: A translated access returns `paddr_o` = {entry bits 8:0, vaddr bits 8:0}. The table base is chosen as follows: user pages 0..255 use base register 1, user pages 256..511 use base register 2, and exec pages 256..511 use base register 3. The word index is page bits 7:1.
- R4: Base register bits 24:19 hold a length and bits 17:0 hold the table origin. If the word index (page bits 7:1) is greater than the length, the block faults without any memory read. An index equal to the length is walked.
- R5: A table word holds the even page's entry in bits 35:18 and the odd page's entry in bits 17:0. A miss fills both, so a later access to the other page of the pair causes no memory traffic.
- R6: On a fill, the 4-bit age replaces bits 12:9 of the accessed half only: word bits 30:27 for an even page, bits 12:9 for an odd page. The word is written back to the address it was read from.
- R7: Entry bits 17:16 are the access code: 00 always faults, 11 permits read and write, and 01/10 permit read only. An access counts as a write when `write_i` or `rmw_i` is set.
- R8: `fault_word_o` = {bit 18 set for a user-map access, page number in bits 17:9, entry bits 8:0}. The entry is zero for a length fault.
- R9: On every fill the 6-bit reload pointer becomes ((pointer+1) mod 32) with bit 5 set. It resets to 0.
- R10: `map_load_i` reads offsets 0, 2, 4, 5, 6 and 7 from the block at `vaddr_i`. These give, in order: the age (word bits 30:27), the trap address (bits 21:0), base registers 1, 2 and 3, and the accumulator pointer (bits 17:0). `done_o` pulses at the end.
- R11: `tlb_clr_i` invalidates every cached entry, so the next access to a page walks the table again.
- R12: `fault_o` stays set until `fault_clr_i`. While it is set, requests and load commands are ignored and `done_o` stays low.
- R13: `mem_req_o` stays high with a stable address and direction until `mem_ack_i`. Results are correct for any acknowledge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request strobe |
| vaddr_i | input | 18 | Virtual address, or block address for a load |
| user_i | input | 1 | User mode when high, exec mode when low |
| write_i | input | 1 | Store access |
| rmw_i | input | 1 | Read-modify-write cycle in progress |
| pg_en_i | input | 1 | Paging enable |
| tlb_clr_i | input | 1 | Invalidate all cache entries |
| fault_clr_i | input | 1 | Acknowledge and clear the fault |
| map_load_i | input | 1 | Load the mapping registers from memory |
| paddr_o | output | 18 | Physical address |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Sticky fault flag |
| fault_word_o | output | 19 | Fault description word |
| reload_ptr_o | output | 6 | Reload pointer |
| trap_addr_o | output | 22 | Trap-address register |
| ac_ptr_o | output | 18 | Accumulator pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high |
| mem_addr_o | output | 18 | Memory word address |
| mem_wdata_o | output | 36 | Memory write data |
| mem_rdata_i | input | 36 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
A wrong base register or length shows up on the very next translation in its region. It appears as a table read at the wrong address or as a length fault that does not belong there, and the write-back then hits the wrong word. A stale or half-filled cache pair shows up as extra or missing memory traffic on the neighbouring page. It can also show as a wrong frame in `paddr_o`, within two edges of the request. A misplaced age stamp or a wrong reload pointer can be seen right after the fill's write-back. A fault flag that leaks or sticks is visible as a spurious or missing `done_o` on the next request.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_RD, ST_WR, ST_LD} st_e;

  localparam int unsigned LD_STEPS = 6;

  // word offsets inside the map-load block, in load order
  function automatic logic [2:0] ld_off(input logic [2:0] step);
    case (step)
      3'd0:    ld_off = 3'd0;
      3'd1:    ld_off = 3'd2;
      3'd2:    ld_off = 3'd4;
      3'd3:    ld_off = 3'd5;
      3'd4:    ld_off = 3'd6;
      default: ld_off = 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/pgx_region.sv
module pgx_region #(
  parameter int VA_W  = 18,
  parameter int OFF_W = 9,
  parameter int LEN_W = 6
) (
  input  logic                      user_i,
  input  logic [VA_W-OFF_W-2:0]     pair_i,
  input  logic [LEN_W+VA_W-1:0]     bu_lo_i,
  input  logic [LEN_W+VA_W-1:0]     bu_hi_i,
  input  logic [LEN_W+VA_W-1:0]     bex_i,
  output logic                      direct_o,
  output logic                      len_flt_o,
  output logic [VA_W-1:0]           tbl_addr_o
);
  localparam int BR_W  = LEN_W + VA_W;
  localparam int IDX_W = VA_W - OFF_W - 2;

  logic             hi;
  logic [IDX_W-1:0] idx;
  logic [BR_W-1:0]  sel;
  logic [LEN_W-1:0] len;

  assign hi  = pair_i[IDX_W];
  assign idx = pair_i[IDX_W-1:0];
  assign sel = !user_i ? bex_i : (hi ? bu_hi_i : bu_lo_i);
  assign len = sel[BR_W-1 -: LEN_W];

  assign direct_o   = !user_i && !hi;
  assign len_flt_o  = idx > IDX_W'(len);
  assign tbl_addr_o = sel[VA_W-1:0] + VA_W'(idx);
endmodule

// File: rtl/pgx_access.sv
module pgx_access #(
  parameter int HALF_W = 18
) (
  input  logic [HALF_W-1:0] entry_i,
  input  logic              wr_i,
  output logic              ok_o
);
  logic [1:0] code;
  assign code = entry_i[HALF_W-1 -: 2];
  assign ok_o = (code != 2'b00) && (!wr_i || code == 2'b11);
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int VPN_W  = 9,
  parameter int HALF_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                rd_user_i,
  input  logic [VPN_W-1:0]    rd_page_i,
  output logic [HALF_W-1:0]   rd_entry_o,
  input  logic                fill_i,
  input  logic                fill_user_i,
  input  logic [VPN_W-2:0]    fill_pair_i,
  input  logic [2*HALF_W-1:0] fill_word_i
);
  localparam int N_UP = 2 ** (VPN_W - 1);
  localparam int N_EP = N_UP / 2;

  logic [2*HALF_W-1:0] u_pair [N_UP];
  logic [2*HALF_W-1:0] e_pair [N_EP];

  for (genvar p = 0; p < N_UP; p++) begin : g_u
    logic [2*HALF_W-1:0] pair_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                                   pair_q <= '0;
      else if (clr_i)                                                pair_q <= '0;
      else if (fill_i && fill_user_i && fill_pair_i == (VPN_W-1)'(p)) pair_q <= fill_word_i;
    assign u_pair[p] = pair_q;
  end

  for (genvar p = 0; p < N_EP; p++) begin : g_e
    logic [2*HALF_W-1:0] pair_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)  pair_q <= '0;
      else if (clr_i) pair_q <= '0;
      else if (fill_i && !fill_user_i && fill_pair_i[VPN_W-3:0] == (VPN_W-2)'(p))
        pair_q <= fill_word_i;
    assign e_pair[p] = pair_q;
  end

  logic [2*HALF_W-1:0] rd_pair;
  assign rd_pair    = rd_user_i ? u_pair[rd_page_i[VPN_W-1:1]] : e_pair[rd_page_i[VPN_W-2:1]];
  // even page in the left half
  assign rd_entry_o = rd_page_i[0] ? rd_pair[HALF_W-1:0] : rd_pair[2*HALF_W-1:HALF_W];
endmodule

// File: rtl/page_xlat.sv
module page_xlat
  import pgx_pkg::*;
#(
  parameter int VA_W   = 18,
  parameter int WORD_W = 36,
  parameter int OFF_W  = 9,
  parameter int LEN_W  = 6,
  parameter int AGE_W  = 4,
  parameter int RP_W   = 6,
  parameter int TRAP_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              user_i,
  input  logic              write_i,
  input  logic              rmw_i,
  input  logic              pg_en_i,
  input  logic              tlb_clr_i,
  input  logic              fault_clr_i,
  input  logic              map_load_i,
  output logic [VA_W-1:0]   paddr_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [VA_W:0]     fault_word_o,
  output logic [RP_W-1:0]   reload_ptr_o,
  output logic [TRAP_W-1:0] trap_addr_o,
  output logic [VA_W-1:0]   ac_ptr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [VA_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam int HALF_W  = WORD_W / 2;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int BR_W    = LEN_W + VA_W;
  localparam int LEN_LSB = VA_W + 1;

  st_e               state_q;
  logic [VA_W-1:0]   va_q, blk_q, paddr_q, acp_q;
  logic              usr_q, wr_q, pen_q, walked_q, done_q, fault_q;
  logic [WORD_W-1:0] wword_q, aged;
  logic [2:0]        step_q;
  logic [BR_W-1:0]   b1_q, b2_q, b3_q;
  logic [AGE_W-1:0]  age_q;
  logic [TRAP_W-1:0] trap_q;
  logic [RP_W-1:0]   rp_q;
  logic [VA_W:0]     fw_q;

  logic [VPN_W-1:0]  page;
  logic              direct, len_flt, ok, fill;
  logic [VA_W-1:0]   tbl_addr;
  logic [HALF_W-1:0] tlb_entry, walk_entry, entry;

  assign page = va_q[VA_W-1:OFF_W];

  pgx_region #(.VA_W(VA_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) i_region (
    .user_i(usr_q), .pair_i(page[VPN_W-1:1]), .bu_lo_i(b1_q), .bu_hi_i(b2_q),
    .bex_i(b3_q), .direct_o(direct), .len_flt_o(len_flt), .tbl_addr_o(tbl_addr));

  assign fill = (state_q == ST_WR) && mem_ack_i;

  pgx_tlb #(.VPN_W(VPN_W), .HALF_W(HALF_W)) i_tlb (
    .clk_i, .rst_ni, .clr_i(tlb_clr_i), .rd_user_i(usr_q), .rd_page_i(page),
    .rd_entry_o(tlb_entry), .fill_i(fill), .fill_user_i(usr_q),
    .fill_pair_i(page[VPN_W-1:1]), .fill_word_i(wword_q));

  assign walk_entry = page[0] ? wword_q[HALF_W-1:0] : wword_q[WORD_W-1:HALF_W];
  // a freshly walked word is used as is, even when its half is zero
  assign entry      = walked_q ? walk_entry : tlb_entry;

  pgx_access #(.HALF_W(HALF_W)) i_access (.entry_i(entry), .wr_i(wr_q), .ok_o(ok));

  always_comb begin
    aged = mem_rdata_i;
    if (page[0]) aged[OFF_W +: AGE_W]          = age_q;
    else         aged[HALF_W + OFF_W +: AGE_W] = age_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q <= '0; blk_q <= '0; paddr_q <= '0; acp_q <= '0;
      usr_q <= 1'b0; wr_q <= 1'b0; pen_q <= 1'b0; walked_q <= 1'b0;
      done_q <= 1'b0; fault_q <= 1'b0; wword_q <= '0; step_q <= '0;
      b1_q <= '0; b2_q <= '0; b3_q <= '0; age_q <= '0; trap_q <= '0;
      rp_q <= '0; fw_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (fault_clr_i) fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          walked_q <= 1'b0;
          if (!fault_q) begin
            if (map_load_i) begin
              blk_q   <= vaddr_i;
              step_q  <= '0;
              state_q <= ST_LD;
            end else if (req_i) begin
              va_q    <= vaddr_i;
              usr_q   <= user_i;
              wr_q    <= write_i | rmw_i;
              pen_q   <= pg_en_i;
              state_q <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          if (!pen_q || direct) begin
            paddr_q <= va_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (!walked_q && entry == '0) begin
            if (len_flt) begin
              fault_q <= 1'b1;
              fw_q    <= {usr_q, page, {OFF_W{1'b0}}};
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_RD;
            end
          end else begin
            if (ok) paddr_q <= {entry[VPN_W-1:0], va_q[OFF_W-1:0]};
            else begin
              fault_q <= 1'b1;
              fw_q    <= {usr_q, page, entry[OFF_W-1:0]};
            end
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_RD: if (mem_ack_i) begin
          wword_q <= aged;
          state_q <= ST_WR;
        end
        ST_WR: if (mem_ack_i) begin
          walked_q <= 1'b1;
          rp_q     <= {1'b1, rp_q[RP_W-2:0] + 1'b1};
          state_q  <= ST_LOOK;
        end
        ST_LD: if (mem_ack_i) begin
          case (step_q)
            3'd0:    age_q  <= mem_rdata_i[HALF_W + OFF_W +: AGE_W];
            3'd1:    trap_q <= mem_rdata_i[TRAP_W-1:0];
            3'd2:    b1_q   <= {mem_rdata_i[LEN_LSB +: LEN_W], mem_rdata_i[VA_W-1:0]};
            3'd3:    b2_q   <= {mem_rdata_i[LEN_LSB +: LEN_W], mem_rdata_i[VA_W-1:0]};
            3'd4:    b3_q   <= {mem_rdata_i[LEN_LSB +: LEN_W], mem_rdata_i[VA_W-1:0]};
            default: acp_q  <= mem_rdata_i[VA_W-1:0];
          endcase
          if (step_q == 3'(LD_STEPS - 1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o    = (state_q == ST_RD) || (state_q == ST_WR) || (state_q == ST_LD);
  assign mem_we_o     = (state_q == ST_WR);
  assign mem_addr_o   = (state_q == ST_LD) ? blk_q + VA_W'(ld_off(step_q)) : tbl_addr;
  assign mem_wdata_o  = wword_q;
  assign paddr_o      = paddr_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_word_o = fw_q;
  assign reload_ptr_o = rp_q;
  assign trap_addr_o  = trap_q;
  assign ac_ptr_o     = acp_q;

  // R12
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !fault_clr_i |=> fault_o);
  // R12
  fault_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && $past(fault_o) |-> !done_o);
  // R13
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R9
  reload_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reload_ptr_o) |-> reload_ptr_o[RP_W-1]);
  // R1
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOOK && !pen_q |=> done_o && !fault_o && paddr_o == $past(va_q));
  // R6
  wb_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RD && mem_ack_i |=> mem_we_o && mem_addr_o == $past(mem_addr_o));
endmodule

// File: tb/test_page_xlat.sv
module test_page_xlat;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req = 0, usr = 0, wr = 0, rmw = 0, pen = 0, tclr = 0, fclr = 0, mload = 0;
  logic [17:0] va = '0;
  logic [17:0] paddr, ac_ptr, maddr;
  logic        done, fault, mreq, mwe;
  logic [18:0] fword;
  logic [5:0]  rptr;
  logic [21:0] trap;
  logic [35:0] mwdata, mrdata = '0;
  logic        mack = 1'b0;

  page_xlat i_page_xlat (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(va), .user_i(usr),
    .write_i(wr), .rmw_i(rmw), .pg_en_i(pen), .tlb_clr_i(tclr),
    .fault_clr_i(fclr), .map_load_i(mload), .paddr_o(paddr), .done_o(done),
    .fault_o(fault), .fault_word_o(fword), .reload_ptr_o(rptr),
    .trap_addr_o(trap), .ac_ptr_o(ac_ptr), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata),
    .mem_ack_i(mack));

  int n_chk = 0, n_err = 0;
  int nrd = 0, nwr = 0, lat = 0, cnt = 0;
  logic [35:0] mem [int];

  function automatic logic [35:0] rd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 36'd0;
  endfunction

  // memory model with adjustable acknowledge latency
  always @(posedge clk) begin
    if (!rst_n) begin mack <= 0; cnt <= 0; end
    else if (mack) begin mack <= 0; cnt <= 0; end
    else if (mreq) begin
      if (cnt >= lat) begin
        mack <= 1;
        if (mwe) begin mem[int'(maddr)] = mwdata; nwr++; end
        else begin mrdata <= rd(maddr); nrd++; end
      end else cnt <= cnt + 1;
    end
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0o expected %0o", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic [17:0] pa;
    logic        flt;
    logic [18:0] fw;
    logic        chk_pa;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  // monitor: pops one expectation per completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) check("R12 unexpected done", 1, 0);
      else begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        check({t, " fault"}, 64'(fault), 64'(e.flt));
        if (e.flt) check({t, " fault word"}, 64'(fword), 64'(e.fw));
        else if (e.chk_pa) check({t, " paddr"}, 64'(paddr), 64'(e.pa));
      end
    end
  end

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xact(input logic [17:0] a, input logic u, input logic w, input logic m,
                      input logic pe, input logic [17:0] pa, input logic f,
                      input logic [18:0] fw, input string tag);
    q.push_back('{pa: pa, flt: f, fw: fw, chk_pa: 1'b1});
    tq.push_back(tag);
    @(negedge clk);
    va = a; usr = u; wr = w; rmw = m; pen = pe; req = 1;
    @(negedge clk);
    req = 0;
    wait_idle();
  endtask

  task automatic load(input logic [17:0] blk);
    q.push_back('{pa: '0, flt: 1'b0, fw: '0, chk_pa: 1'b0});
    tq.push_back("R10 load");
    @(negedge clk);
    va = blk; mload = 1;
    @(negedge clk);
    mload = 0;
    wait_idle();
  endtask

  task automatic clr_fault();
    @(negedge clk); fclr = 1;
    @(negedge clk); fclr = 0;
  endtask

  task automatic clr_tlb();
    @(negedge clk); tclr = 1;
    @(negedge clk); tclr = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int r0, w0;
    mem[32'o100] = (36'd5 << 27) | 36'o17;
    mem[32'o101] = 36'o555;
    mem[32'o102] = 36'o1234567;
    mem[32'o103] = 36'o666;
    mem[32'o104] = (36'd3 << 19) | 36'o1000;
    mem[32'o105] = 36'o2000;
    mem[32'o106] = (36'd1 << 19) | 36'o3000;
    mem[32'o107] = {18'o123456, 18'o000777};
    mem[32'o1000] = {18'o600123, 18'o200045};
    mem[32'o1001] = {18'o000077, 18'o000000};
    mem[32'o2000] = {18'o600200, 18'o400201};
    mem[32'o3001] = {18'o600300, 18'o000000};

    repeat (3) @(negedge clk);
    check("reset done", 64'(done), 0);
    check("reset fault", 64'(fault), 0);
    check("R9 reset reload", 64'(rptr), 0);
    check("reset mem_req", 64'(mreq), 0);
    rst_n = 1;

    load(18'o100);
    check("R10 trap", 64'(trap), 64'(22'o1234567));
    check("R10 ac ptr", 64'(ac_ptr), 64'(18'o777));
    check("R10 reads", 64'(nrd), 6);

    r0 = nrd;
    xact(18'o654321, 1, 1, 0, 0, 18'o654321, 0, 0, "R1 paging off");
    check("R1 no memory", 64'(nrd), 64'(r0));
    xact(18'o012345, 0, 1, 0, 1, 18'o012345, 0, 0, "R2 exec direct");
    check("R2 no memory", 64'(nrd), 64'(r0));

    xact(18'o000017, 1, 0, 0, 1, 18'o123017, 0, 0, "R3 user low");
    check("R5 fill read", 64'(nrd), 64'(r0 + 1));
    check("R6 age even", 64'(rd(18'o1000)), 64'({18'o605123, 18'o200045}));
    check("R9 reload", 64'(rptr), 64'(6'o41));

    r0 = nrd; w0 = nwr;
    xact(18'o001005, 1, 0, 0, 1, 18'o045005, 0, 0, "R5 pair hit");
    check("R5 no traffic", 64'(nrd + nwr), 64'(r0 + w0));
    check("R6 other half untouched", 64'(rd(18'o1000)), 64'({18'o605123, 18'o200045}));

    xact(18'o001005, 1, 1, 0, 1, 0, 1, 19'o1001045, "R7 write read-only");
    // requests while faulted must be ignored (monitor flags any done)
    @(negedge clk); va = 18'o000017; usr = 1; wr = 0; pen = 1; req = 1;
    @(negedge clk); req = 0;
    repeat (10) @(negedge clk);
    check("R12 fault held", 64'(fault), 1);
    clr_fault();
    check("R12 fault cleared", 64'(fault), 0);

    xact(18'o000400, 1, 0, 1, 1, 18'o123400, 0, 0, "R7 rmw on rw page");
    xact(18'o001000, 1, 0, 1, 1, 0, 1, 19'o1001045, "R7 rmw on read-only");
    clr_fault();

    xact(18'o002000, 1, 0, 0, 1, 0, 1, 19'o1002077, "R7 code 00");
    check("R9 reload 2", 64'(rptr), 64'(6'o42));
    clr_fault();

    r0 = nrd;
    xact(18'o010000, 1, 0, 0, 1, 0, 1, 19'o1010000, "R4 length");
    check("R4 no read", 64'(nrd), 64'(r0));
    clr_fault();
    xact(18'o007000, 1, 0, 0, 1, 0, 1, 19'o1007000, "R4 index equal length walked");
    check("R4 equal walks", 64'(nrd), 64'(r0 + 1));
    clr_fault();

    xact(18'o401123, 1, 0, 0, 1, 18'o201123, 0, 0, "R3 user high");
    xact(18'o401123, 1, 1, 0, 1, 0, 1, 19'o1401201, "R7 code 10 write");
    clr_fault();
    xact(18'o402000, 1, 0, 0, 1, 0, 1, 19'o1402000, "R4 user high length");
    clr_fault();

    xact(18'o402777, 0, 0, 0, 1, 18'o300777, 0, 0, "R3 exec high");
    xact(18'o404000, 0, 1, 0, 1, 0, 1, 19'o0404000, "R8 exec fault word");
    clr_fault();

    clr_tlb();
    r0 = nrd;
    xact(18'o000017, 1, 0, 0, 1, 18'o123017, 0, 0, "R11 after clear");
    check("R11 rewalk", 64'(nrd), 64'(r0 + 1));

    lat = 3;
    clr_tlb();
    xact(18'o001777, 1, 0, 0, 1, 18'o045777, 0, 0, "R13 slow memory");
    check("R13 age odd", 64'(rd(18'o1000)), 64'({18'o605123, 18'o205045}));
    check("R9 reload final", 64'(rptr), 64'(6'o47));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule